// File: doc/BRIEF.md
# Receive Sampling-Tap Window Search

This block finds a good receive sampling point for a high-speed card interface. On a start request it steps the sampling tap upward from zero across a fixed range. For each tap it programs the tap into the control register through a request/acknowledge handshake, asks an external checker to run a tuning-block test, and records whether the tap passed. While it sweeps, it tracks the longest run of consecutive passing taps. At the end it programs the tap in the middle of that run. If no tap passed, it reports an error.

Every tap is written twice in a row, and each write waits for its acknowledge. This works around a timing weakness in the receive path. A write that is not acknowledged within a bounded number of cycles is abandoned, and that tap counts as failed. The search runs only when the high-speed tuned mode input is set. In any other mode a start request completes at once without touching the interface.

Top module: `tap_window_search`

## Requirements
- R1: The sweep tests taps 0 through TAP_COUNT-1 (default 40, so 0..39) in strictly ascending order, each tap at most once.
- R2: A tap counts as failed when its write is not acknowledged or its tuning test reports fail. A failure clears the current run length. After a failed write, no tuning test is requested for that tap.
- R3: A pass adds one to the current run. The best run length and its end tap change only when the current run becomes strictly longer than the best, so of two equally long runs the earlier one is kept.
- R4: After the sweep, the block writes the tap best_end - floor(best_len/2) through the same handshake and shows it on result_tap_o.
- R5: If no tap passed, done_o comes with err_o = 1, no final write is made, and result_tap_o keeps its previous value.
- R6: Each tap write raises apply_req_o twice, one request after the other. Each request is held with a stable apply_tap_o until apply_ack_i (a one-cycle pulse) arrives. A fully acknowledged write therefore takes exactly two acknowledges. apply_req_o and test_req_o are never high together.
- R7: If no acknowledge arrives within ACK_TIMEOUT cycles of a request, the request is dropped and the write counts as failed.
- R8: With hs200_i = 0 at start, the block signals done with err_o = 0. It raises no apply or test request and leaves result_tap_o unchanged.
- R9: busy_o is high from the cycle after start until the done cycle, inclusive. done_o lasts exactly one cycle, and err_o is valid while it is high.
- R10: A start pulse while busy_o is high is ignored. It neither changes the result nor produces an extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a search (sampled while idle) |
| hs200_i | input | 1 | 1 = tuned high-speed mode, run the search; 0 = bypass |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No passing tap or final write failed; valid with done_o |
| result_tap_o | output | TAP_W | Tap programmed by the last successful search |
| apply_req_o | output | 1 | Tap write request to the control register |
| apply_tap_o | output | TAP_W | Tap value carried by the write request |
| apply_ack_i | input | 1 | One-cycle write acknowledge |
| test_req_o | output | 1 | Request a tuning-block test at the current tap |
| test_done_i | input | 1 | One-cycle test completion |
| test_pass_i | input | 1 | Test outcome, valid with test_done_i |

## Verification
The assertions assume that apply_ack_i and test_done_i are single-cycle pulses and that each arrives only while its own request is high. The bench responders meet this. They raise an acknowledge only after seeing a request, and they drop it on the next half cycle, before the request can be raised again. The acknowledge latency is kept well under ACK_TIMEOUT for every tap except the ones the bench deliberately leaves unanswered. start_i is a single-cycle pulse, except in the one case that checks that a start arriving during a search is ignored.

// File: rtl/tws_pkg.sv
package tws_pkg;

   typedef enum logic [2:0] {
      TOP_IDLE,
      TOP_LAUNCH,
      TOP_APPLY,
      TOP_TEST,
      TOP_STEP,
      TOP_DECIDE,
      TOP_FINAL,
      TOP_DONE
   } top_state_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_REQ,
      SEQ_GAP
   } seq_state_e;

endpackage

// File: rtl/tws_apply_seq.sv
module tws_apply_seq
   import tws_pkg::*;
#(
   parameter int TAP_W        = 6,
   parameter int APPLY_REPEAT = 2,
   parameter int ACK_TIMEOUT  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [TAP_W-1:0] tap_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic [TAP_W-1:0] tap_o,
   output logic             done_o,
   output logic             ok_o
);
   localparam int REP_W = $clog2(APPLY_REPEAT + 1);
   localparam int TMO_W = $clog2(ACK_TIMEOUT);
   localparam logic [REP_W-1:0] REP_LAST = REP_W'(APPLY_REPEAT - 1);
   localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(ACK_TIMEOUT - 1);

   generate
      if (APPLY_REPEAT < 1) begin : g_bad_rep
         $error("APPLY_REPEAT must be at least 1");
      end
      if (ACK_TIMEOUT < 2) begin : g_bad_tmo
         $error("ACK_TIMEOUT must be at least 2");
      end
   endgenerate

   seq_state_e       st;
   logic [REP_W-1:0] rep;
   logic [TMO_W-1:0] tmo;

   assign req_o = (st == SEQ_REQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SEQ_IDLE;
         rep    <= '0;
         tmo    <= '0;
         tap_o  <= '0;
         done_o <= 1'b0;
         ok_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            SEQ_IDLE: begin
               if (start_i) begin
                  tap_o <= tap_i;
                  rep   <= '0;
                  tmo   <= '0;
                  st    <= SEQ_REQ;
               end
            end
            SEQ_REQ: begin
               if (ack_i) begin
                  if (rep == REP_LAST) begin
                     done_o <= 1'b1;
                     ok_o   <= 1'b1;
                     st     <= SEQ_IDLE;
                  end else begin
                     rep <= rep + 1'b1;
                     st  <= SEQ_GAP;
                  end
               end else if (tmo == TMO_LAST) begin
                  done_o <= 1'b1;
                  ok_o   <= 1'b0;
                  st     <= SEQ_IDLE;
               end else begin
                  tmo <= tmo + 1'b1;
               end
            end
            SEQ_GAP: begin
               tmo <= '0;
               st  <= SEQ_REQ;
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end

   // R6: a pending request keeps its tap until acknowledged or timed out
   a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      req_o && !ack_i && (tmo != TMO_LAST) |=> req_o && $stable(tap_o));

   // R7: an unanswered request at the limit ends the write as failed
   a_r7_timeout_fail: assert property (@(posedge clk) disable iff (!rst_n)
      req_o && !ack_i && (tmo == TMO_LAST) |=> done_o && !ok_o && !req_o);

endmodule

// File: rtl/tws_run_tracker.sv
module tws_run_tracker #(
   parameter int TAP_W      = 6,
   parameter int LEN_W      = 6,
   parameter bit KEEP_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             upd_i,
   input  logic             pass_i,
   input  logic [TAP_W-1:0] tap_i,
   output logic [LEN_W-1:0] best_len_o,
   output logic [TAP_W-1:0] centre_o
);
   logic [LEN_W-1:0] cur_len;
   logic [LEN_W-1:0] cur_next;
   logic [TAP_W-1:0] best_end;
   logic             improve;

   assign cur_next = cur_len + 1'b1;

   generate
      if (KEEP_FIRST) begin : g_keep_first
         assign improve = cur_next > best_len_o;
      end else begin : g_keep_last
         assign improve = cur_next >= best_len_o;
      end
   endgenerate

   assign centre_o = best_end - TAP_W'(best_len_o >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_len    <= '0;
         best_len_o <= '0;
         best_end   <= '0;
      end else if (clr_i) begin
         cur_len    <= '0;
         best_len_o <= '0;
         best_end   <= '0;
      end else if (upd_i) begin
         if (pass_i) begin
            cur_len <= cur_next;
            if (improve) begin
               best_len_o <= cur_next;
               best_end   <= tap_i;
            end
         end else begin
            cur_len <= '0;
         end
      end
   end

   // R2: a failing tap clears the running length
   a_r2_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i && !pass_i && !clr_i |=> cur_len == '0);

   // R3: the best run only grows within one search
   a_r3_best_grows: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> best_len_o >= $past(best_len_o));

   // R3: the current run never exceeds the recorded best
   a_r3_cur_le_best: assert property (@(posedge clk) disable iff (!rst_n)
      cur_len <= best_len_o);

endmodule

// File: rtl/tap_window_search.sv
module tap_window_search
   import tws_pkg::*;
#(
   parameter int TAP_W        = 6,
   parameter int TAP_COUNT    = 40,
   parameter int APPLY_REPEAT = 2,
   parameter int ACK_TIMEOUT  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             hs200_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic [TAP_W-1:0] result_tap_o,
   output logic             apply_req_o,
   output logic [TAP_W-1:0] apply_tap_o,
   input  logic             apply_ack_i,
   output logic             test_req_o,
   input  logic             test_done_i,
   input  logic             test_pass_i
);
   localparam int LEN_W = $clog2(TAP_COUNT + 1);
   localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(TAP_COUNT - 1);

   generate
      if (TAP_COUNT < 1 || TAP_COUNT > (1 << TAP_W)) begin : g_bad_range
         $error("TAP_COUNT must fit in TAP_W bits");
      end
   endgenerate

   top_state_e       state;
   logic [TAP_W-1:0] tap_q;
   logic [TAP_W-1:0] result_q;
   logic             err_q;

   logic             seq_start;
   logic [TAP_W-1:0] seq_tap;
   logic             seq_done;
   logic             seq_ok;
   logic             rec_clr;
   logic             rec_upd;
   logic             rec_pass;
   logic [LEN_W-1:0] best_len;
   logic [TAP_W-1:0] centre;

   assign busy_o       = (state != TOP_IDLE);
   assign done_o       = (state == TOP_DONE);
   assign err_o        = err_q;
   assign result_tap_o = result_q;
   assign test_req_o   = (state == TOP_TEST);

   always_comb begin
      seq_start = (state == TOP_LAUNCH) ||
                  ((state == TOP_DECIDE) && (best_len != '0));
      seq_tap   = (state == TOP_DECIDE) ? centre : tap_q;
      rec_clr   = (state == TOP_IDLE) && start_i && hs200_i;
      rec_upd   = ((state == TOP_APPLY) && seq_done && !seq_ok) ||
                  ((state == TOP_TEST) && test_done_i);
      rec_pass  = (state == TOP_TEST) && test_pass_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TOP_IDLE;
         tap_q    <= '0;
         result_q <= '0;
         err_q    <= 1'b0;
      end else begin
         case (state)
            TOP_IDLE: begin
               if (start_i) begin
                  err_q <= 1'b0;
                  tap_q <= '0;
                  state <= hs200_i ? TOP_LAUNCH : TOP_DONE;
               end
            end
            TOP_LAUNCH: state <= TOP_APPLY;
            TOP_APPLY: begin
               if (seq_done) state <= seq_ok ? TOP_TEST : TOP_STEP;
            end
            TOP_TEST: begin
               if (test_done_i) state <= TOP_STEP;
            end
            TOP_STEP: begin
               if (tap_q == TAP_LAST) begin
                  state <= TOP_DECIDE;
               end else begin
                  tap_q <= tap_q + 1'b1;
                  state <= TOP_LAUNCH;
               end
            end
            TOP_DECIDE: begin
               if (best_len == '0) begin
                  err_q <= 1'b1;
                  state <= TOP_DONE;
               end else begin
                  state <= TOP_FINAL;
               end
            end
            TOP_FINAL: begin
               if (seq_done) begin
                  err_q <= !seq_ok;
                  if (seq_ok) result_q <= apply_tap_o;
                  state <= TOP_DONE;
               end
            end
            TOP_DONE: state <= TOP_IDLE;
            default:  state <= TOP_IDLE;
         endcase
      end
   end

   tws_apply_seq #(
      .TAP_W       (TAP_W),
      .APPLY_REPEAT(APPLY_REPEAT),
      .ACK_TIMEOUT (ACK_TIMEOUT)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(seq_start),
      .tap_i  (seq_tap),
      .ack_i  (apply_ack_i),
      .req_o  (apply_req_o),
      .tap_o  (apply_tap_o),
      .done_o (seq_done),
      .ok_o   (seq_ok)
   );

   tws_run_tracker #(
      .TAP_W     (TAP_W),
      .LEN_W     (LEN_W),
      .KEEP_FIRST(1'b1)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (rec_clr),
      .upd_i     (rec_upd),
      .pass_i    (rec_pass),
      .tap_i     (tap_q),
      .best_len_o(best_len),
      .centre_o  (centre)
   );

   // R9: done lasts one cycle and falls inside busy
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R6: write and test requests never overlap
   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(apply_req_o && test_req_o));

   // R1: tests only run on taps inside the sweep range
   a_r1_tap_range: assert property (@(posedge clk) disable iff (!rst_n)
      test_req_o |-> apply_tap_o <= TAP_LAST);

endmodule

// File: tb/tap_window_search_tb.sv
module tap_window_search_tb;
   localparam int NT  = 40;
   localparam int TW  = 6;
   localparam int TMO = 16;

   typedef struct {
      string    tag;
      bit       hs;
      bit       err;
      int       tap;
      int       acks;
      int       tests;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          hs200_i = 1'b1;
   logic          busy_o, done_o, err_o, apply_req_o, test_req_o;
   logic [TW-1:0] result_tap_o, apply_tap_o;
   logic          apply_ack_i = 1'b0;
   logic          test_done_i = 1'b0;
   logic          test_pass_i = 1'b0;

   always #4 clk = ~clk;

   tap_window_search #(.TAP_W(TW), .TAP_COUNT(NT), .APPLY_REPEAT(2),
                       .ACK_TIMEOUT(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .hs200_i(hs200_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .result_tap_o(result_tap_o), .apply_req_o(apply_req_o),
      .apply_tap_o(apply_tap_o), .apply_ack_i(apply_ack_i),
      .test_req_o(test_req_o), .test_done_i(test_done_i),
      .test_pass_i(test_pass_i)
   );

   int        checks = 0;
   int        fails = 0;
   exp_t      exp_q[$];
   bit [NT-1:0] pass_pat;
   bit [NT-1:0] noack;
   int        lat = 0;
   int        wcnt = 0;
   int        ack_cnt = 0;
   int        test_cnt = 0;
   int        last_tap = 0;
   int        prev_test = -1;
   bit        order_bad = 1'b0;
   int        done_cnt = 0;
   int        cycles = 0;
   logic [TW-1:0] prev_result = '0;

   task automatic check(input bit ok, input string req, input string tag,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, expv);
      end
   endtask

   // Write responder: acknowledge after lat cycles unless the tap is blocked
   always @(negedge clk) begin
      if (apply_ack_i) begin
         apply_ack_i <= 1'b0;
      end else if (apply_req_o) begin
         if (!noack[apply_tap_o]) begin
            if (wcnt >= lat) begin
               apply_ack_i <= 1'b1;
               ack_cnt++;
               last_tap = int'(apply_tap_o);
               wcnt = 0;
            end else begin
               wcnt++;
            end
         end
      end else begin
         wcnt = 0;
      end
   end

   // Tuning-test responder
   always @(negedge clk) begin
      if (test_done_i) begin
         test_done_i <= 1'b0;
      end else if (test_req_o) begin
         test_done_i <= 1'b1;
         test_pass_i <= pass_pat[last_tap];
         test_cnt++;
         if (last_tap <= prev_test || last_tap >= NT) order_bad = 1'b1;
         prev_test = last_tap;
      end
   end

   // Monitor: pop the expected item on each done and compare
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         exp_t e;
         done_cnt++;
         check(busy_o === 1'b1, "R9 busy at done", "mon", busy_o, 1);
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 extra done", "mon", 1, 0);
         end else begin
            e = exp_q.pop_front();
            check(err_o === e.err, "R5 err", e.tag, err_o, e.err);
            if (e.hs && !e.err)
               check(int'(result_tap_o) == e.tap, "R4 tap", e.tag,
                     result_tap_o, e.tap);
            else
               check(result_tap_o == prev_result, "R5/R8 tap kept", e.tag,
                     result_tap_o, prev_result);
            check(ack_cnt == e.acks, "R6 acks", e.tag, ack_cnt, e.acks);
            check(test_cnt == e.tests, "R2 tests", e.tag, test_cnt, e.tests);
            check(!order_bad, "R1 order", e.tag, order_bad, 0);
         end
      end
   end

   // Driver: compute the expectation and launch one search
   task automatic run_case(input string tag, input bit hs,
                           input bit [NT-1:0] pat, input bit [NT-1:0] blk,
                           input int l, input bit poke);
      exp_t e;
      int cur = 0, best = 0, bend = 0, good_ack = 0;
      for (int i = 0; i < NT; i++) begin
         if (!blk[i]) good_ack++;
         if (pat[i] && !blk[i]) begin
            cur++;
            if (cur > best) begin best = cur; bend = i; end
         end else begin
            cur = 0;
         end
      end
      e.tag = tag;
      e.hs  = hs;
      if (hs) begin
         e.err   = (best == 0);
         e.tap   = bend - best / 2;
         e.tests = good_ack;
         e.acks  = 2 * good_ack + (e.err ? 0 : 2);
      end else begin
         e.err = 1'b0; e.tap = 0; e.tests = 0; e.acks = 0;
      end
      @(posedge clk); #1;
      pass_pat = pat; noack = blk; lat = l;
      ack_cnt = 0; test_cnt = 0; prev_test = -1; order_bad = 1'b0;
      prev_result = result_tap_o;
      exp_q.push_back(e);
      hs200_i = hs; start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      check(busy_o === 1'b1, "R9 busy after start", tag, busy_o, 1);
      if (poke) begin
         repeat (50) @(posedge clk);
         #1; hs200_i = 1'b0; start_i = 1'b1;   // R10: ignored while busy
         @(posedge clk); #1; start_i = 1'b0; hs200_i = hs;
      end
      while (exp_q.size() != 0) @(posedge clk);
      repeat (5) @(posedge clk);
      #1;
      check(busy_o === 1'b0 && done_o === 1'b0, "R9 idle after done", tag,
            busy_o, 0);
   endtask

   initial begin
      bit [NT-1:0] p;
      pass_pat = '0; noack = '0;
      repeat (3) @(posedge clk);
      #1;
      check(busy_o === 1'b0, "reset busy", "rst", busy_o, 0);
      check(done_o === 1'b0 && err_o === 1'b0, "reset done/err", "rst", done_o, 0);
      check(apply_req_o === 1'b0 && test_req_o === 1'b0, "reset reqs", "rst",
            apply_req_o, 0);
      check(result_tap_o === '0, "reset tap", "rst", result_tap_o, 0);
      rst_n = 1'b1;

      run_case("R4 all pass", 1, '1, '0, 0, 0);
      run_case("R5 none pass", 1, '0, '0, 1, 0);
      p = '0; p[0] = 1'b1;
      run_case("R1 first only", 1, p, '0, 0, 0);
      p = '0; p[NT-1] = 1'b1;
      run_case("R1 last only", 1, p, '0, 2, 0);
      p = '0; p[9:5] = '1; p[24:20] = '1;
      run_case("R3 tie keeps first", 1, p, '0, 0, 0);
      p = '0; p[5:3] = '1; p[17:10] = '1;
      run_case("R3 longer later", 1, p, '0, 3, 0);
      p = '0; p[13:10] = '1; p[32:30] = '1;
      run_case("R4 even length", 1, p, '0, 1, 0);
      p = '0; p[20] = 1'b1;
      run_case("R7 timeout splits run", 1, '1, p, 0, 0);
      p = '0; p[31:26] = '1;
      run_case("R2 fail inside run", 1, 40'h00_7BFC_0000, '0, 0, 0);
      run_case("R8 bypass", 0, '1, '0, 0, 0);
      p = '0; p[33:28] = '1;
      run_case("R10 start while busy", 1, p, '0, 0, 1);
      check(done_cnt == 11, "R10 done count", "end", done_cnt, 11);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule